// File: doc/BRIEF.md
# Bytecode to Microcode Translation Stage

This stage sits at the front of a stack-machine pipeline. It takes a stream of bytecode opcodes and turns each one into the entry address of its routine in the microcode store. It then steps through that routine one microinstruction address per cycle. A simple opcode maps onto exactly one microinstruction, so it occupies a single cycle. A complex opcode runs a short routine of consecutive addresses. No trap is taken, and no cycles are lost between routines.

Every presented address comes with a "last" flag. This is the flag a microinstruction uses to ask for the next bytecode. While a routine is still running, the opcode input is held off with a ready/valid handshake.

Interrupts are taken here and nowhere else. When a request is pending at a bytecode boundary, a fixed interrupt opcode is translated in place of the incoming byte, and the request is acknowledged in the same cycle. The stages after this one therefore carry no interrupt logic.

The sequencer is a three-state machine:
- `ST_IDLE` means nothing is presented.
- `ST_ROUTINE` means a non-final microinstruction is presented.
- `ST_FINAL` means the last microinstruction of a routine is presented.

Its transitions are:
- IDLE to FINAL: a one-instruction opcode is loaded.
- IDLE to ROUTINE: a longer opcode is loaded.
- ROUTINE to ROUTINE: more than one instruction remains.
- ROUTINE to FINAL: one instruction remains.
- FINAL to FINAL: a one-instruction opcode is loaded back to back.
- FINAL to ROUTINE: a longer opcode is loaded back to back.
- FINAL to IDLE: nothing is loaded.

Top module: `bcx_translate`

## Requirements
- R1: After reset, `u_valid` and `u_last` are 0 and `irq_ack` is 0. With `irq_req` low, `bc_ready` is 1.
- R2: An accepted opcode below 0x80 is presented in the next cycle with `u_addr` equal to the opcode value and `u_last` = 1. It takes exactly one cycle.
- R3: An accepted opcode `op` of 0x80 or above has its routine start at `u_addr` = 128 + 8·(op − 128). The routine runs for (op mod 4) + 2 consecutive addresses, one per cycle, and `u_last` is 1 only on the final one.
- R4: While a non-final microinstruction is presented, `bc_ready` is 0 and the held opcode is not consumed.
- R5: At a boundary, with no valid opcode and no interrupt request, the next cycle presents nothing (`u_valid` = 0).
- R6: At a boundary, a high `irq_req` raises `irq_ack` and lowers `bc_ready` in that same cycle. The next cycle starts the routine of interrupt opcode 0xF3, which is entry 1048 with length 5.
- R7: An interrupt request that arrives mid-routine is not acknowledged until the cycle that presents the routine's last microinstruction.
- R8: An opcode or interrupt is accepted in the cycle that presents a last microinstruction (`u_last` = 1). Its first microinstruction follows in the next cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_valid | input | 1 | Opcode byte available |
| bc_data | input | 8 | Opcode byte |
| bc_ready | output | 1 | Opcode consumed this cycle when valid |
| irq_req | input | 1 | Level interrupt request, held until acknowledged |
| irq_ack | output | 1 | Interrupt taken this cycle |
| u_valid | output | 1 | A microinstruction address is presented |
| u_addr | output | 11 | Microcode store address |
| u_last | output | 1 | Presented microinstruction requests the next bytecode |

## Verification
The properties take two things for granted about the inputs:
- A raised `bc_valid` keeps its `bc_data` unchanged until the cycle in which `bc_ready` is high.
- `irq_req` stays high until `irq_ack` is seen.

The stimulus follows both rules. Each opcode is held in a pending slot until the reference model reports it accepted, and each interrupt request stays raised until the modelled acknowledge cycle. Opcodes are drawn from both the simple and the complex ranges, and the interrupt opcode itself is also sent as ordinary input.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ROUTINE = 2'd1,
        ST_FINAL   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bcx_xlat.sv
module bcx_xlat #(
    parameter int OP_W   = 8,
    parameter int UA_W   = 11,
    parameter int LEN_W  = 3,
    parameter int SLOT_W = 3
) (
    input  logic [OP_W-1:0]  op,
    output logic [UA_W-1:0]  entry,
    output logic [LEN_W-1:0] len_m1
);
    localparam int NUM_OPS = 1 << OP_W;
    localparam int HALF    = NUM_OPS / 2;

    logic [UA_W-1:0]  entry_tab [NUM_OPS];
    logic [LEN_W-1:0] len_tab   [NUM_OPS];

    // Lower half: direct one-instruction mapping.
    // Upper half: slots of 2**SLOT_W words.
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_tab
        if (i < HALF) begin : g_simple
            assign entry_tab[i] = UA_W'(i);
            assign len_tab[i]   = '0;
        end else begin : g_complex
            assign entry_tab[i] = UA_W'(HALF + ((i - HALF) << SLOT_W));
            assign len_tab[i]   = LEN_W'((i % 4) + 1);
        end
    end

    assign entry  = entry_tab[op];
    assign len_m1 = len_tab[op];

endmodule

// File: rtl/bcx_inject.sv
module bcx_inject #(
    parameter int          OP_W   = 8,
    parameter logic [7:0]  IRQ_OP = 8'hF3
) (
    input  logic            boundary,
    input  logic            bc_valid,
    input  logic [OP_W-1:0] bc_data,
    input  logic            irq_req,
    output logic            bc_ready,
    output logic            irq_ack,
    output logic            load,
    output logic [OP_W-1:0] sel_op
);
    // Interrupt wins over the byte stream, only at a bytecode boundary.
    assign irq_ack  = boundary && irq_req;
    assign bc_ready = boundary && !irq_req;
    assign load     = irq_ack || (bc_ready && bc_valid);
    assign sel_op   = irq_req ? OP_W'(IRQ_OP) : bc_data;

endmodule

// File: rtl/bcx_useq.sv
module bcx_useq
    import bcx_pkg::*;
#(
    parameter int UA_W  = 11,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [UA_W-1:0]  entry,
    input  logic [LEN_W-1:0] len_m1,
    output logic             boundary,
    output logic             u_valid,
    output logic [UA_W-1:0]  u_addr,
    output logic             u_last
);
    seq_state_e       state_q, state_d;
    logic [UA_W-1:0]  addr_q;
    logic [LEN_W-1:0] left_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINAL: begin
                if (load)
                    state_d = (len_m1 == '0) ? ST_FINAL : ST_ROUTINE;
                else
                    state_d = ST_IDLE;
            end
            ST_ROUTINE: begin
                state_d = (left_q == LEN_W'(1)) ? ST_FINAL : ST_ROUTINE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Address and remaining-count datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (state_q == ST_ROUTINE) begin
            addr_q <= addr_q + UA_W'(1);
            left_q <= left_q - LEN_W'(1);
        end else if (load) begin
            addr_q <= entry;
            left_q <= len_m1;
        end
    end

    // Outputs from state
    always_comb begin
        u_valid  = 1'b0;
        u_last   = 1'b0;
        boundary = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROUTINE: begin
                u_valid  = 1'b1;
                boundary = 1'b0;
            end
            ST_FINAL: begin
                u_valid = 1'b1;
                u_last  = 1'b1;
            end
            default: ;
        endcase
    end

    assign u_addr = addr_q;

endmodule

// File: rtl/bcx_translate.sv
module bcx_translate #(
    parameter int         OP_W   = 8,
    parameter int         UA_W   = 11,
    parameter int         LEN_W  = 3,
    parameter int         SLOT_W = 3,
    parameter logic [7:0] IRQ_OP = 8'hF3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bc_valid,
    input  logic [OP_W-1:0] bc_data,
    output logic            bc_ready,
    input  logic            irq_req,
    output logic            irq_ack,
    output logic            u_valid,
    output logic [UA_W-1:0] u_addr,
    output logic            u_last
);
    logic             boundary;
    logic             load;
    logic [OP_W-1:0]  sel_op;
    logic [UA_W-1:0]  entry;
    logic [LEN_W-1:0] len_m1;

    bcx_inject #(.OP_W(OP_W), .IRQ_OP(IRQ_OP)) u_inject (
        .boundary (boundary),
        .bc_valid (bc_valid),
        .bc_data  (bc_data),
        .irq_req  (irq_req),
        .bc_ready (bc_ready),
        .irq_ack  (irq_ack),
        .load     (load),
        .sel_op   (sel_op)
    );

    bcx_xlat #(.OP_W(OP_W), .UA_W(UA_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_xlat (
        .op     (sel_op),
        .entry  (entry),
        .len_m1 (len_m1)
    );

    bcx_useq #(.UA_W(UA_W), .LEN_W(LEN_W)) u_useq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .entry    (entry),
        .len_m1   (len_m1),
        .boundary (boundary),
        .u_valid  (u_valid),
        .u_addr   (u_addr),
        .u_last   (u_last)
    );

endmodule

// File: rtl/bcx_translate_chk.sv
module bcx_translate_chk #(
    parameter int OP_W = 8,
    parameter int UA_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bc_valid,
    input logic [OP_W-1:0] bc_data,
    input logic            bc_ready,
    input logic            irq_req,
    input logic            irq_ack,
    input logic            u_valid,
    input logic [UA_W-1:0] u_addr,
    input logic            u_last
);
    localparam int HALF = (1 << OP_W) / 2;

    logic at_edge;
    assign at_edge = !u_valid || u_last;

    // R2: simple opcode presented next cycle at its own value, single cycle
    a_r2_simple_map: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && bc_ready && (int'(bc_data) < HALF))
        |=> (u_valid && u_last && (u_addr == UA_W'($past(bc_data)))));

    // R3: routine addresses advance by one until the last
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && !u_last) |=> (u_valid && (u_addr == $past(u_addr) + UA_W'(1))));

    // R4: input held off mid-routine
    a_r4_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && !u_last) |-> !bc_ready);

    // R5: idle bubble when nothing to load
    a_r5_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (at_edge && !bc_valid && !irq_req) |=> !u_valid);

    // R6: acknowledge excludes byte acceptance
    a_r6_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (!bc_ready && irq_req));

    // R7: no acknowledge inside a routine
    a_r7_no_mid_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && !u_last) |-> !irq_ack);

    // R8: a load at a last instruction gives a presentation next cycle
    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (u_last && (irq_ack || (bc_valid && bc_ready))) |=> u_valid);

endmodule

bind bcx_translate bcx_translate_chk #(.OP_W(OP_W), .UA_W(UA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bc_valid (bc_valid),
    .bc_data  (bc_data),
    .bc_ready (bc_ready),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .u_valid  (u_valid),
    .u_addr   (u_addr),
    .u_last   (u_last)
);

// File: tb/bcx_translate_bench.sv
module bcx_translate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bc_valid = 1'b0;
    logic [7:0]  bc_data = 8'h00;
    logic        irq_req = 1'b0;
    logic        bc_ready, irq_ack, u_valid, u_last;
    logic [10:0] u_addr;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // Behavioural reference state
    bit m_valid = 0;
    int m_addr  = 0;
    int m_rem   = 0;
    bit acc_flag, ack_flag;

    always #2.5 clk = ~clk;

    bcx_translate u_bcx_translate (
        .clk(clk), .rst_n(rst_n), .bc_valid(bc_valid), .bc_data(bc_data),
        .bc_ready(bc_ready), .irq_req(irq_req), .irq_ack(irq_ack),
        .u_valid(u_valid), .u_addr(u_addr), .u_last(u_last)
    );

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit m_edge();
        return !m_valid || (m_rem == 0);
    endfunction

    task automatic m_load(int op);
        m_valid = 1;
        if (op < 128) begin
            m_addr = op;
            m_rem  = 0;
        end else begin
            m_addr = 128 + 8 * (op - 128);
            m_rem  = (op % 4) + 1;
        end
    endtask

    // One clock: drive at negedge, check handshake, advance model, check outputs.
    task automatic step(bit v, int d, bit irq);
        bc_valid = v;
        bc_data  = 8'(d);
        irq_req  = irq;
        #1;
        ack_flag = m_edge() && irq;
        acc_flag = m_edge() && !irq && v;
        check("bc_ready", int'(bc_ready), int'(m_edge() && !irq));
        check("irq_ack", int'(irq_ack), int'(ack_flag));
        @(posedge clk);
        if (m_edge()) begin
            if (irq)    m_load(8'hF3);
            else if (v) m_load(d);
            else        m_valid = 0;
        end else begin
            m_addr++;
            m_rem--;
        end
        @(negedge clk);
        check("u_valid", int'(u_valid), int'(m_valid));
        if (m_valid) begin
            check("u_addr", int'(u_addr), m_addr);
            check("u_last", int'(u_last), int'(m_rem == 0));
        end
    endtask

    // Hold an opcode until accepted (R4 exercised while waiting)
    task automatic send(int d);
        do step(1, d, 0); while (!acc_flag);
    endtask

    initial begin
        bit hv, hirq;
        int hd;
        repeat (3) @(negedge clk);
        tag = "R1";
        check("reset u_valid", int'(u_valid), 0);
        check("reset u_last", int'(u_last), 0);
        check("reset irq_ack", int'(irq_ack), 0);
        check("reset bc_ready", int'(bc_ready), 1);
        rst_n = 1'b1;

        tag = "R2";
        send(8'h00); send(8'h7F);
        tag = "R8";
        send(8'h11); send(8'h80); send(8'h22);
        tag = "R3";
        send(8'h83); send(8'hFE); send(8'hF3);
        tag = "R4";
        send(8'h81); send(8'h05);
        tag = "R5";
        repeat (3) step(0, 0, 0);
        tag = "R6";
        do step(0, 0, 1); while (!ack_flag);
        step(1, 8'h42, 0);
        tag = "R7";
        send(8'h82);
        step(0, 0, 1);
        do step(1, 8'h10, 1); while (!ack_flag);
        send(8'h10);
        repeat (8) step(0, 0, 0);

        tag = "R8";
        hv = 0; hirq = 0; hd = 0;
        for (int i = 0; i < 2000; i++) begin
            if (!hv && ($urandom % 3 != 0)) begin
                hv = 1;
                hd = int'($urandom % 256);
            end
            if (!hirq && ($urandom % 25 == 0)) hirq = 1;
            step(hv, hd, hirq);
            if (ack_flag) hirq = 0;
            if (acc_flag) hv = 0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule